// File: doc/BRIEF.md
# Sprite and crosshair cursor overlay

This block produces a per-pixel overlay select code for a hardware cursor on a noninterlaced raster display. It follows the raster from two active-low inputs, a sync and a blank, and works out the screen coordinate of every displayed pixel. Two cursors share the screen. One is a 64x64 sprite whose pattern, two bits per pixel, sits in an external pattern memory. The other is a full-screen crosshair made of a horizontal band and a vertical band of programmable thickness.

The sprite is placed by a cursor position and an origin (hot spot) offset. During the back porch of each line, the block copies the sprite row for the coming line into a local line buffer. Pattern memory is therefore read only while the screen is blanked. A 7-bit control word selects the sprite decoding mode, turns each cursor on or off, sets the crosshair colour and thickness, and chooses which cursor wins where the two overlap. Downstream palette logic turns the 3-bit select into a colour.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `ovl_sel` reads 0 (pass video through).
- R2: x is 0 on the first active pixel of every line and rises by one per active pixel. y rises by one per line. Two or more falling edges of `sync_n` inside one blanking interval mark vertical retrace, and the next active line is y = 0.
- R3: The sprite's top-left corner is at (`cur_x` - `org_x`, `cur_y` - `org_y`). Pattern pixel (col,row) appears at corner + (col,row). Parts that fall off any screen edge, including corners with negative coordinates, are simply not shown.
- R4: Pattern byte address is row*16 + col/4. Within a byte, the leftmost of the four pixels occupies bits [7:6] and the rightmost occupies bits [1:0].
- R5: With `ctrl_reg[4]`=0, pattern codes 00, 01, 10 and 11 give `ovl_sel` 1 (colour 0), 2 (colour 1), 0 (transparent) and 3 (inverted video).
- R6: With `ctrl_reg[4]`=1, codes 00 and 01 are transparent (0), code 10 gives 1 (colour 0) and code 11 gives 2 (colour 1). Inverted video never occurs in this mode.
- R7: With `ctrl_reg[2]`=1, pixels with |x-`cur_x`| <= h or |y-`cur_y`| <= h show the crosshair, where h = `ctrl_reg[1:0]` (thickness 2h+1). The crosshair gives `ovl_sel` 4 when `ctrl_reg[3]`=0 and 5 when it is 1. With `ctrl_reg[2]`=0, codes 4 and 5 never appear.
- R8: Where a non-transparent sprite pixel and the crosshair coincide, `ctrl_reg[5]`=0 shows the sprite code and `ctrl_reg[5]`=1 shows the crosshair code. Where the sprite pixel is transparent, the crosshair shows.
- R9: With `ctrl_reg[6]`=0, no sprite code (1, 2, 3) appears anywhere.
- R10: A pixel sampled with `blank_n` high gives its code on `ovl_sel` one clock later. A blanked cycle gives 0.
- R11: Each row prefetch starts at the rising edge of `sync_n` inside blanking and performs 16 consecutive reads with one-cycle read latency. `pat_rd` is never high while `blank_n` is high, provided the back porch lasts at least 18 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Active-low sync |
| blank_n | input | 1 | Low during blanking, high on displayed pixels |
| ctrl_reg | input | 7 | Control word: [6] sprite on, [5] overlap picks crosshair, [4] alternate sprite decoding, [3] crosshair colour, [2] crosshair on, [1:0] crosshair half-width |
| cur_x | input | 12 | Cursor x position |
| cur_y | input | 12 | Cursor y position |
| org_x | input | 6 | Sprite hot-spot column |
| org_y | input | 6 | Sprite hot-spot row |
| pat_rd | output | 1 | Pattern memory read strobe |
| pat_addr | output | 10 | Pattern memory byte address |
| pat_data | input | 8 | Pattern memory data, valid the cycle after `pat_rd` |
| ovl_sel | output | 3 | Registered overlay select for the pixel of the previous cycle |

## Verification
Two functions can claim the same pixel: the sprite decode and the crosshair band. The bench sets up frames in which the crosshair passes through the sprite, with the overlap bit both clear and set and with each decoding mode. Transparent, coloured and inverting pattern codes all fall under the bands. A scoreboard model computes the winner for every pixel from the requirements, and each pixel is checked as it leaves the block. Overlap pixels are reported under their own requirement tag.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

   localparam int PIX_BITS = 2;

   typedef enum logic [2:0] {
      OVL_VIDEO  = 3'd0,
      OVL_SPR_C0 = 3'd1,
      OVL_SPR_C1 = 3'd2,
      OVL_INVERT = 3'd3,
      OVL_XH_C0  = 3'd4,
      OVL_XH_C1  = 3'd5
   } ovl_sel_e;

   // field order mirrors control bits 6 down to 0
   typedef struct packed {
      logic       spr_en;
      logic       overlap_xh;
      logic       xwin_mode;
      logic       xh_color;
      logic       xh_en;
      logic [1:0] xh_half;
   } cur_ctrl_t;

   function automatic ovl_sel_e decode_sprite(input logic [PIX_BITS-1:0] code,
                                              input logic xwin);
      ovl_sel_e r;
      if (xwin) begin
         unique case (code)
            2'b10:   r = OVL_SPR_C0;
            2'b11:   r = OVL_SPR_C1;
            default: r = OVL_VIDEO;
         endcase
      end else begin
         unique case (code)
            2'b00:   r = OVL_SPR_C0;
            2'b01:   r = OVL_SPR_C1;
            2'b10:   r = OVL_VIDEO;
            default: r = OVL_INVERT;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/raster_track.sv
module raster_track #(
   parameter int COORD_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_n,
   input  logic               blank_n,
   output logic [COORD_W-1:0] pix_x,
   output logic [COORD_W-1:0] pix_y,
   output logic               fetch_go
);

   logic sync_q, blank_q, sync_seen;
   logic sync_fall, sync_rise, blank_start;

   assign sync_fall   = sync_q & ~sync_n;
   assign sync_rise   = ~sync_q & sync_n;
   assign blank_start = blank_q & ~blank_n;
   // row prefetch starts as sync ends, leaving the whole back porch for it
   assign fetch_go    = ~blank_n & sync_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q    <= 1'b1;
         blank_q   <= 1'b0;
         sync_seen <= 1'b0;
         pix_x     <= '0;
         pix_y     <= '1;
      end else begin
         sync_q  <= sync_n;
         blank_q <= blank_n;
         pix_x   <= blank_n ? pix_x + COORD_W'(1) : '0;
         if (blank_start)
            sync_seen <= sync_fall;
         else if (!blank_n && sync_fall)
            sync_seen <= 1'b1;
         // R2: second sync inside one blank means vertical retrace
         if (!blank_n && !blank_start && sync_fall && sync_seen)
            pix_y <= '0;
         else if (blank_start)
            pix_y <= pix_y + COORD_W'(1);
      end
   end

endmodule

// File: rtl/pattern_fetch.sv
module pattern_fetch #(
   parameter int SPRITE_DIM  = 64,
   parameter int MEM_W       = 8,
   parameter bit MSB_FIRST   = 1'b1,
   localparam int BPP        = cursor_ovl_pkg::PIX_BITS,
   localparam int PPW        = MEM_W / BPP,
   localparam int WPR        = SPRITE_DIM / PPW,
   localparam int LOG_DIM    = $clog2(SPRITE_DIM),
   localparam int WI_W       = $clog2(WPR),
   localparam int PIX_W      = $clog2(PPW),
   localparam int ADDR_W     = LOG_DIM + WI_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               blank_n,
   input  logic               fetch_go,
   input  logic [LOG_DIM-1:0] row,
   input  logic               row_ok,
   input  logic [LOG_DIM-1:0] rd_col,
   output logic               pat_rd,
   output logic [ADDR_W-1:0]  pat_addr,
   input  logic [MEM_W-1:0]   pat_data,
   output logic               line_ok,
   output logic [BPP-1:0]     pix_code
);

   logic               busy, wr_v;
   logic [WI_W-1:0]    rd_idx, wr_idx;
   logic [LOG_DIM-1:0] row_q;
   logic [BPP-1:0]     unpk   [PPW];
   logic [BPP-1:0]     line_q [SPRITE_DIM];

   // R4: picks which end of the word holds the leftmost pixel
   for (genvar p = 0; p < PPW; p++) begin : g_pix
      if (MSB_FIRST) begin : g_msb
         assign unpk[p] = pat_data[(PPW-1-p)*BPP +: BPP];
      end else begin : g_lsb
         assign unpk[p] = pat_data[p*BPP +: BPP];
      end
   end

   assign pat_rd   = busy;
   assign pat_addr = {row_q, rd_idx};
   assign pix_code = line_q[rd_col];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         wr_v    <= 1'b0;
         rd_idx  <= '0;
         wr_idx  <= '0;
         row_q   <= '0;
         line_ok <= 1'b0;
      end else begin
         wr_v   <= busy;
         wr_idx <= rd_idx;
         if (fetch_go) begin
            busy    <= 1'b1;
            rd_idx  <= '0;
            row_q   <= row;
            line_ok <= row_ok;
         end else if (busy) begin
            rd_idx <= rd_idx + WI_W'(1);
            if (rd_idx == WI_W'(WPR-1))
               busy <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_v) begin
         for (int p = 0; p < PPW; p++)
            line_q[{wr_idx, PIX_W'(p)}] <= unpk[p];
      end
   end

   assert_read_in_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pat_rd |-> !blank_n);

endmodule

// File: rtl/overlay_mix.sv
module overlay_mix
   import cursor_ovl_pkg::*;
#(
   parameter int COORD_W = 12,
   localparam int SW     = COORD_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                blank_n,
   input  logic [COORD_W-1:0]  pix_x,
   input  logic [COORD_W-1:0]  pix_y,
   input  logic [COORD_W-1:0]  cur_x,
   input  logic [COORD_W-1:0]  cur_y,
   input  cur_ctrl_t           ctrl,
   input  logic                spr_present,
   input  logic [PIX_BITS-1:0] spr_code,
   output ovl_sel_e            ovl_q
);

   logic signed [SW-1:0] dx, dy, half;
   logic                 in_v, in_h, xh_on, spr_vis;
   ovl_sel_e             spr_sel, xh_sel, nxt;

   assign dx   = SW'(pix_x) - SW'(cur_x);
   assign dy   = SW'(pix_y) - SW'(cur_y);
   assign half = SW'(ctrl.xh_half);
   assign in_v = (dx >= -half) && (dx <= half);
   assign in_h = (dy >= -half) && (dy <= half);

   assign xh_on   = ctrl.xh_en & (in_v | in_h);
   assign xh_sel  = ctrl.xh_color ? OVL_XH_C1 : OVL_XH_C0;
   assign spr_sel = decode_sprite(spr_code, ctrl.xwin_mode);
   assign spr_vis = ctrl.spr_en & spr_present & (spr_sel != OVL_VIDEO);

   always_comb begin
      if (spr_vis && xh_on)
         nxt = ctrl.overlap_xh ? xh_sel : spr_sel;
      else if (spr_vis)
         nxt = spr_sel;
      else if (xh_on)
         nxt = xh_sel;
      else
         nxt = OVL_VIDEO;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovl_q <= OVL_VIDEO;
      else
         ovl_q <= blank_n ? nxt : OVL_VIDEO;
   end

   assert_blank_video_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |=> ovl_q == OVL_VIDEO);
   assert_no_xh_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.xh_en |=> (ovl_q != OVL_XH_C0) && (ovl_q != OVL_XH_C1));
   assert_no_sprite_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.spr_en |=> (ovl_q == OVL_VIDEO) || (ovl_q == OVL_XH_C0) || (ovl_q == OVL_XH_C1));
   assert_xwin_no_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.xwin_mode |=> ovl_q != OVL_INVERT);
   assert_all_off_video_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.xh_en && !ctrl.spr_en) |=> ovl_q == OVL_VIDEO);

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_ovl_pkg::*;
#(
   parameter int COORD_W       = 12,
   parameter int SPRITE_DIM    = 64,
   parameter int MEM_W         = 8,
   parameter bit PIX_MSB_FIRST = 1'b1
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     sync_n,
   input  logic                                     blank_n,
   input  logic [6:0]                               ctrl_reg,
   input  logic [COORD_W-1:0]                       cur_x,
   input  logic [COORD_W-1:0]                       cur_y,
   input  logic [$clog2(SPRITE_DIM)-1:0]            org_x,
   input  logic [$clog2(SPRITE_DIM)-1:0]            org_y,
   output logic                                     pat_rd,
   output logic [$clog2(SPRITE_DIM*SPRITE_DIM*2/MEM_W)-1:0] pat_addr,
   input  logic [MEM_W-1:0]                         pat_data,
   output logic [2:0]                               ovl_sel
);

   localparam int LOG_DIM = $clog2(SPRITE_DIM);
   localparam int PPW     = MEM_W / PIX_BITS;
   localparam int WPR     = SPRITE_DIM / PPW;
   localparam int SW      = COORD_W + 2;
   localparam logic signed [SW-1:0] DIM_S = SW'(SPRITE_DIM);

   if ((1 << LOG_DIM) != SPRITE_DIM || SPRITE_DIM < 8) begin : g_bad_dim
      $error("SPRITE_DIM must be a power of two of at least 8");
   end
   if (MEM_W % PIX_BITS != 0 || (1 << $clog2(PPW)) != PPW || PPW < 2 || WPR < 2) begin : g_bad_mem
      $error("MEM_W must hold a power-of-two count (>=2) of pixels, below one row");
   end
   if (COORD_W <= LOG_DIM) begin : g_bad_coord
      $error("COORD_W must exceed the sprite index width");
   end

   cur_ctrl_t            ctrl;
   logic [COORD_W-1:0]   pix_x, pix_y;
   logic                 fetch_go, line_ok, row_ok, col_ok;
   logic signed [SW-1:0] cnr_x, cnr_y, col_off, row_off;
   logic [PIX_BITS-1:0]  pix_code;
   ovl_sel_e             ovl_q;

   assign ctrl = cur_ctrl_t'(ctrl_reg);

   // R3: corner = position minus hot spot, may be negative
   assign cnr_x   = SW'(cur_x) - SW'(org_x);
   assign cnr_y   = SW'(cur_y) - SW'(org_y);
   assign col_off = SW'(pix_x) - cnr_x;
   assign row_off = SW'(pix_y) - cnr_y;
   assign col_ok  = !col_off[SW-1] && (col_off < DIM_S);
   assign row_ok  = !row_off[SW-1] && (row_off < DIM_S);

   raster_track #(.COORD_W(COORD_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_n   (sync_n),
      .blank_n  (blank_n),
      .pix_x    (pix_x),
      .pix_y    (pix_y),
      .fetch_go (fetch_go)
   );

   pattern_fetch #(
      .SPRITE_DIM (SPRITE_DIM),
      .MEM_W      (MEM_W),
      .MSB_FIRST  (PIX_MSB_FIRST)
   ) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .blank_n  (blank_n),
      .fetch_go (fetch_go),
      .row      (row_off[LOG_DIM-1:0]),
      .row_ok   (row_ok),
      .rd_col   (col_off[LOG_DIM-1:0]),
      .pat_rd   (pat_rd),
      .pat_addr (pat_addr),
      .pat_data (pat_data),
      .line_ok  (line_ok),
      .pix_code (pix_code)
   );

   overlay_mix #(.COORD_W(COORD_W)) u_mix (
      .clk         (clk),
      .rst_n       (rst_n),
      .blank_n     (blank_n),
      .pix_x       (pix_x),
      .pix_y       (pix_y),
      .cur_x       (cur_x),
      .cur_y       (cur_y),
      .ctrl        (ctrl),
      .spr_present (line_ok & col_ok),
      .spr_code    (pix_code),
      .ovl_q       (ovl_q)
   );

   assign ovl_sel = ovl_q;

   assert_reset_video_R1: assert property (@(posedge clk)
      !rst_n |=> ovl_sel == 3'd0);

endmodule

// File: tb/cursor_overlay_tb_top.sv
module cursor_overlay_tb_top;

   localparam int W = 100, H = 72, FP = 2, SYN = 8, BP = 84, VGAP = 20;

   logic       clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1, blank_n = 1'b0;
   logic [6:0] ctrl_reg = '0;
   logic [11:0] cur_x = '0, cur_y = '0;
   logic [5:0]  org_x = '0, org_y = '0;
   logic        pat_rd;
   logic [9:0]  pat_addr;
   logic [7:0]  pat_data = '0;
   logic [2:0]  ovl_sel;

   always #5 clk = ~clk;

   cursor_overlay dut_i (
      .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .blank_n(blank_n),
      .ctrl_reg(ctrl_reg), .cur_x(cur_x), .cur_y(cur_y),
      .org_x(org_x), .org_y(org_y), .pat_rd(pat_rd), .pat_addr(pat_addr),
      .pat_data(pat_data), .ovl_sel(ovl_sel)
   );

   typedef struct {
      logic [2:0] exp;
      string      tag;
      int         x;
      int         y;
   } item_t;

   item_t sbq[$];
   int    n_chk = 0, n_fail = 0, rd_active = 0, rd_total = 0;
   bit    done = 1'b0;

   function automatic logic [7:0] pat_fn(input int a);
      int t;
      t = a * 97 + (a >> 4) * 13;
      return 8'(t) ^ 8'h3c;
   endfunction

   // pattern memory model with one-cycle read latency
   always @(posedge clk) pat_data <= pat_fn(int'(pat_addr));

   always @(posedge clk) if (rst_n && pat_rd) begin
      rd_total++;
      if (blank_n) rd_active++;
   end

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic model(input int x, input int y, output logic [2:0] e, output string tag);
      int cx, cy, col, row, code, h, spr, xh;
      bit inwin, svis, xon;
      logic [7:0] b;
      cx = int'(cur_x) - int'(org_x);
      cy = int'(cur_y) - int'(org_y);
      col = x - cx;
      row = y - cy;
      inwin = (col >= 0) && (col < 64) && (row >= 0) && (row < 64);
      spr = 0;
      if (inwin) begin
         b = pat_fn(row * 16 + col / 4);
         code = (b >> (6 - 2 * (col % 4))) & 3;   // R4 leftmost pixel in [7:6]
         if (ctrl_reg[4]) spr = (code == 2) ? 1 : (code == 3) ? 2 : 0;
         else             spr = (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 0 : 3;
      end
      svis = ctrl_reg[6] && inwin && (spr != 0);
      h = int'(ctrl_reg[1:0]);
      xon = ctrl_reg[2] && (iabs(x - int'(cur_x)) <= h || iabs(y - int'(cur_y)) <= h);
      xh = ctrl_reg[3] ? 5 : 4;
      if (svis && xon) begin e = ctrl_reg[5] ? 3'(xh) : 3'(spr); tag = "R8"; end
      else if (svis) begin e = 3'(spr); tag = ctrl_reg[4] ? "R4/R6" : "R4/R5"; end
      else if (xon)  begin e = 3'(xh); tag = "R7"; end
      else begin
         e = 3'd0;
         if (inwin && !ctrl_reg[6]) tag = "R9";
         else if (inwin) tag = ctrl_reg[4] ? "R6" : "R5";
         else if (y == 0) tag = "R2";
         else tag = "R3";
      end
   endtask

   task automatic drive(input bit s, input bit bl, input int x, input int y);
      item_t it;
      @(negedge clk);
      sync_n  = s;
      blank_n = bl;
      it.x = x;
      it.y = y;
      if (!bl) begin it.exp = 3'd0; it.tag = "R10"; end
      else model(x, y, it.exp, it.tag);
      sbq.push_back(it);
   endtask

   // monitor: the pixel sampled at an edge shows one cycle later (R10)
   always @(posedge clk) begin
      #3;
      if (sbq.size() > 0) begin
         item_t it;
         it = sbq.pop_front();
         n_chk++;
         if (ovl_sel !== it.exp) begin
            n_fail++;
            $display("FAIL %s pixel (%0d,%0d): actual %0d expected %0d",
                     it.tag, it.x, it.y, ovl_sel, it.exp);
         end
      end
   end

   task automatic run_frame(input logic [6:0] c, input int px, input int py,
                            input int ox, input int oy);
      for (int i = 0; i < FP; i++) drive(1'b1, 1'b0, 0, 0);
      ctrl_reg = c;
      cur_x = 12'(px);
      cur_y = 12'(py);
      org_x = 6'(ox);
      org_y = 6'(oy);
      // R2: three syncs in one blank mark vertical retrace
      for (int s = 0; s < 3; s++) begin
         for (int i = 0; i < SYN; i++) drive(1'b0, 1'b0, 0, 0);
         for (int i = 0; i < ((s < 2) ? VGAP : BP); i++) drive(1'b1, 1'b0, 0, 0);
      end
      for (int y = 0; y < H; y++) begin
         for (int x = 0; x < W; x++) drive(1'b1, 1'b1, x, y);
         if (y != H - 1) begin
            for (int i = 0; i < FP; i++)  drive(1'b1, 1'b0, 0, 0);
            for (int i = 0; i < SYN; i++) drive(1'b0, 1'b0, 0, 0);
            for (int i = 0; i < BP; i++)  drive(1'b1, 1'b0, 0, 0);
         end
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      n_chk++;
      if (ovl_sel !== 3'd0) begin
         n_fail++;
         $display("FAIL R1 in reset: actual %0d expected 0", ovl_sel);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (ovl_sel !== 3'd0) begin
         n_fail++;
         $display("FAIL R1 after reset: actual %0d expected 0", ovl_sel);
      end
      run_frame(7'h40, 40, 30, 10, 5);   // R5 sprite only, clipped at bottom
      run_frame(7'h5D, 60, 20, 0, 0);    // R6 with crosshair width 3, sprite wins
      run_frame(7'h67, 5, 3, 20, 20);    // R3 negative corner, R8 crosshair wins
      run_frame(7'h0E, 99, 71, 0, 0);    // R9 sprite off, crosshair at far corner
      run_frame(7'h50, 99, 71, 63, 63);  // R6 sprite near bottom-right edge
      run_frame(7'h00, 50, 50, 0, 0);    // both cursors off
      repeat (4) drive(1'b1, 1'b0, 0, 0);
      repeat (3) @(negedge clk);
      n_chk++;
      if (rd_active != 0 || rd_total == 0) begin
         n_fail++;
         $display("FAIL R11 reads in active video: actual %0d (of %0d) expected 0",
                  rd_active, rd_total);
      end
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(10 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL R10 watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule